// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block holds a small bank of pulse channels that follow a nanosecond time counter held elsewhere. A channel does nothing until the alarm it is bound to reports a match. It then emits its first pulse. After that it emits one pulse each time the counter time it has seen advance reaches the programmed period. The time counter itself is outside the block. It reaches the block as a per-cycle advance strobe plus the integer step in nanoseconds that the counter adds on each advance. The alarm comparators are also outside and arrive as one-cycle match pulses.

Each channel is set up by one byte of a shared control word: a disable bit, a mode bit, an alarm-select bit and a 5-bit width. Each channel also has a 32-bit interval word, which holds the wanted period minus one step. The fractional remainder left when a period is not a whole number of steps is carried forward, so the average period stays exact. A pulse lasts a whole number of output-clock periods. The output clock is the block clock divided by the prescale value, and each channel restarts its own divider at every pulse so that the width does not depend on phase. Every pulse sets a sticky event flag, which software clears by writing ones.

For the train to be usable, the period should lie between four output-clock periods plus one step and 2^32-1 plus one step, and the width should be shorter than the period.

Top module: `ppg_bank`

## Requirements
- R1: After a synchronous reset, every pulse output is low, every event flag is 0 and every channel waits for an alarm.
- R2: A channel that is enabled and waiting starts only on the alarm named by bit 5 of its control byte (0 picks alarm_hit[0], 1 picks alarm_hit[1]). A match on the other alarm changes no output and no flag.
- R3: When the selected alarm is sampled high at a clock edge, the channel's first pulse is visible on pulse_out right after that same edge.
- R4: Once running, the channel fires on the advance strobe at which the nanoseconds counted since the previous ideal pulse time reach interval+step. Any excess carries into the next period.
- R5: In pulse mode (bit 6 = 0), the output stays high for exactly W*D clock cycles from the firing edge, where W is bits 4:0 and D is the prescale value (0 acts as 1). If W = 0, no pulse appears, but the event flag is still set.
- R6: In toggle mode (bit 6 = 1), the output inverts at every firing and the width field is ignored.
- R7: When disable (bit 7) is set, the output goes low one cycle later, and no firing, alarm or event happens while it stays set. Clearing it leaves the channel waiting for a new alarm.
- R8: A firing on channel i sets event_flags bit 7-i. Bits 4:0 stay 0. A 1 in event_clr clears the matching flag, but a firing in the same cycle wins.
- R9: Alarm matches that arrive while a channel is running do not shift its pulse timing.
- R10: The control byte of channel i is ctrl_word[8i+7:8i], and its interval is interval_ns[32i+31:32i]. The channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference for the prescaler |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time counter advanced by step_ns in this cycle |
| step_ns | input | STEP_W | Integer nanoseconds added per advance |
| alarm_hit | input | NALM | One-cycle alarm match pulses |
| ctrl_word | input | 8*NCH | One control byte per channel |
| interval_ns | input | IV_W*NCH | Period minus one step, per channel |
| prescale | input | PRSC_W | Output-clock divider |
| event_clr | input | 8 | Write-one-to-clear for event flags |
| pulse_out | output | NCH | Pulse outputs, registered |
| event_flags | output | 8 | Sticky per-channel firing flags |

## Verification
The hardest case to reach from the ports is a step that does not divide the period. Here the carried excess makes the cycle spacing between pulses vary, for example 4, 3, 3, 4. The stimulus produces this in two ways. A directed run uses step 3 and period 10. Seeded random rounds draw a step, a period and a width for each channel and start all channels with a single pair of alarms. The bench predicts each spacing with a function that accumulates nanoseconds per advance, and it compares this against the rising edges it records.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int CTRL_W  = 8;
  localparam int WIDTH_W = 5;
  localparam int EV_W    = 8;

  // Field order matters: packed cast of one control byte
  typedef struct packed {
    logic               dis;
    logic               toggle;
    logic               asel;
    logic [WIDTH_W-1:0] width;
  } ch_ctrl_t;
endpackage

// File: rtl/ppg_interval.sv
module ppg_interval #(
  parameter int IV_W   = 32,
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dis,
  input  logic              arm_hit,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic [IV_W-1:0]   interval,
  output logic              fire,
  output logic              running
);
  localparam int ACC_W = IV_W + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] iv_ext;
  logic             due;

  assign iv_ext = ACC_W'(interval);
  assign due    = acc >= iv_ext;

  always_comb begin
    if (dis)          fire = 1'b0;
    else if (running) fire = tick && due;
    else              fire = arm_hit;
  end

  always_ff @(posedge clk) begin
    if (rst || dis) begin
      running <= 1'b0;
      acc     <= '0;
    end else if (!running) begin
      if (arm_hit) running <= 1'b1;
      acc <= '0;
    end else if (tick) begin
      if (due) acc <= acc - iv_ext;
      else     acc <= acc + ACC_W'(step);
    end
  end

  AST_FIRE_RUNS: assert property (@(posedge clk) disable iff (rst)
    fire |=> running); // R3
endmodule

// File: rtl/ppg_shaper.sv
module ppg_shaper #(
  parameter int PRSC_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        dis,
  input  logic                        fire,
  input  logic                        toggle,
  input  logic [ppg_pkg::WIDTH_W-1:0] width,
  input  logic [PRSC_W-1:0]           prsc,
  output logic                        pulse
);
  import ppg_pkg::*;

  logic [WIDTH_W-1:0] units_left;
  logic [PRSC_W-1:0]  div_cnt;
  logic [PRSC_W-1:0]  div_last;

  assign div_last = (prsc == '0) ? '0 : prsc - PRSC_W'(1);

  always_ff @(posedge clk) begin
    if (rst || dis) begin
      pulse      <= 1'b0;
      units_left <= '0;
      div_cnt    <= '0;
    end else if (fire) begin
      if (toggle) begin
        pulse <= ~pulse;
      end else if (width != '0) begin
        pulse      <= 1'b1;
        units_left <= width;
        div_cnt    <= div_last;
      end else begin
        pulse <= 1'b0;
      end
    end else if (pulse && !toggle) begin
      if (div_cnt == '0) begin
        div_cnt <= div_last;
        if (units_left <= WIDTH_W'(1)) begin
          pulse      <= 1'b0;
          units_left <= '0;
        end else begin
          units_left <= units_left - WIDTH_W'(1);
        end
      end else begin
        div_cnt <= div_cnt - PRSC_W'(1);
      end
    end
  end

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
    dis |=> !pulse); // R7
  AST_FIRE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (fire && !toggle && width != '0) |=> pulse); // R5
endmodule

// File: rtl/ppg_bank.sv
module ppg_bank #(
  parameter int NCH    = 3,
  parameter int NALM   = 2,
  parameter int IV_W   = 32,
  parameter int STEP_W = 10,
  parameter int PRSC_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             tick,
  input  logic [STEP_W-1:0]                step_ns,
  input  logic [NALM-1:0]                  alarm_hit,
  input  logic [NCH*ppg_pkg::CTRL_W-1:0]   ctrl_word,
  input  logic [NCH*IV_W-1:0]              interval_ns,
  input  logic [PRSC_W-1:0]                prescale,
  input  logic [ppg_pkg::EV_W-1:0]         event_clr,
  output logic [NCH-1:0]                   pulse_out,
  output logic [ppg_pkg::EV_W-1:0]         event_flags
);
  import ppg_pkg::*;

  logic [NCH-1:0]  fire_w;
  logic [EV_W-1:0] ev_set;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ch_ctrl_t cc;
    logic     arm;
    logic     run_w;

    assign cc  = ch_ctrl_t'(ctrl_word[i*CTRL_W +: CTRL_W]);
    assign arm = alarm_hit[cc.asel];

    ppg_interval #(.IV_W(IV_W), .STEP_W(STEP_W)) u_iv (
      .clk      (clk),
      .rst      (rst),
      .dis      (cc.dis),
      .arm_hit  (arm),
      .tick     (tick),
      .step     (step_ns),
      .interval (interval_ns[i*IV_W +: IV_W]),
      .fire     (fire_w[i]),
      .running  (run_w)
    );

    ppg_shaper #(.PRSC_W(PRSC_W)) u_sh (
      .clk    (clk),
      .rst    (rst),
      .dis    (cc.dis),
      .fire   (fire_w[i]),
      .toggle (cc.toggle),
      .width  (cc.width),
      .prsc   (prescale),
      .pulse  (pulse_out[i])
    );

    AST_EVT_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
      fire_w[i] |=> event_flags[EV_W-1-i]); // R8
  end

  always_comb begin
    ev_set = '0;
    for (int i = 0; i < NCH; i++) ev_set[EV_W-1-i] = fire_w[i];
  end

  always_ff @(posedge clk) begin
    if (rst) event_flags <= '0;
    else     event_flags <= (event_flags & ~event_clr) | ev_set;
  end
endmodule

// File: tb/sim_ppg_bank.sv
`timescale 1ns/1ps
module sim_ppg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [9:0]  step_ns = 10'd1;
  logic [1:0]  alarm_hit = 2'b00;
  logic [23:0] ctrl_word = 24'h808080;
  logic [95:0] interval_ns = '1;
  logic [7:0]  prescale = 8'd2;
  logic [7:0]  event_clr = 8'h00;
  logic [2:0]  pulse_out;
  logic [7:0]  event_flags;

  ppg_bank u0 (
    .clk(clk), .rst(rst), .tick(tick), .step_ns(step_ns),
    .alarm_hit(alarm_hit), .ctrl_word(ctrl_word),
    .interval_ns(interval_ns), .prescale(prescale),
    .event_clr(event_clr), .pulse_out(pulse_out),
    .event_flags(event_flags)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // rising-edge monitor
  int   cyc_n = 0;
  int   rc [3];
  int   rt [3][16];
  int   hl [3];
  int   hs [3];
  logic pv [3];

  initial for (int i = 0; i < 3; i++) begin rc[i] = 0; hl[i] = -1; hs[i] = 0; pv[i] = 1'b0; end

  always @(negedge clk) begin
    cyc_n++;
    for (int i = 0; i < 3; i++) begin
      if (pulse_out[i] && !pv[i]) begin
        if (rc[i] < 16) rt[i][rc[i]] = cyc_n;
        rc[i]++;
        hs[i] = cyc_n;
      end
      if (!pulse_out[i] && pv[i]) hl[i] = cyc_n - hs[i];
      pv[i] = pulse_out[i];
    end
  end

  task automatic clear_mon();
    for (int i = 0; i < 3; i++) begin rc[i] = 0; hl[i] = -1; end
  endtask

  task automatic chk(input longint act, input longint exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
  endtask

  task automatic pulse_alarm(input logic [1:0] a);
    alarm_hit = a; cyc(1); alarm_hit = 2'b00;
  endtask

  // advances needed until accumulated ns since last ideal pulse reach p
  function automatic int nticks(input longint e, input longint s, input longint p);
    int n = 1;
    while (e + n * s < p) n++;
    return n;
  endfunction

  task automatic check_spacing(input int ch, input longint s, input longint p,
                               input int cnt, input string tag);
    longint e = 0;
    for (int k = 0; k < cnt; k++) begin
      int n = nticks(e, s, p);
      e = e + n * s - p;
      chk(rt[ch][k+1] - rt[ch][k], n, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    chk(pulse_out, 0, "R1 pulse after reset");
    chk(event_flags, 0, "R1 flags after reset");

    // R2/R3/R5/R8 directed
    ctrl_word = 24'h808022;            // ch0: asel=1, width=2
    interval_ns[31:0] = 32'd100;
    prescale = 8'd2; tick = 1'b0;
    pulse_alarm(2'b01);
    cyc(3);
    chk(pulse_out[0], 0, "R2 wrong alarm ignored (pulse)");
    chk(event_flags, 0, "R2 wrong alarm ignored (flags)");
    alarm_hit = 2'b10; cyc(1); alarm_hit = 2'b00;
    chk(pulse_out[0], 1, "R3 first pulse right after alarm edge");
    chk(event_flags, 8'h80, "R8 ch0 sets bit 7");
    cyc(3);
    chk(pulse_out[0], 1, "R5 still high at W*D-1");
    cyc(1);
    chk(pulse_out[0], 0, "R5 low after W*D cycles");
    event_clr = 8'h80; cyc(1); event_clr = 8'h00;
    chk(event_flags, 0, "R8 write-one clear");
    ctrl_word = 24'h800122;            // ch1: asel=0, width=1
    alarm_hit = 2'b01; event_clr = 8'h40; cyc(1);
    alarm_hit = 2'b00; event_clr = 8'h00;
    chk(event_flags, 8'h40, "R8 set wins over clear");
    chk(pulse_out[1], 1, "R10 ch1 independent start");
    ctrl_word = 24'h000122;            // ch2: width 0
    pulse_alarm(2'b01);
    chk(pulse_out[2], 0, "R5 width zero gives no pulse");
    chk(event_flags, 8'h60, "R5 width zero still flags bit 5");

    // R4/R9 fractional phase
    do_reset();
    ctrl_word = 24'h808001; interval_ns[31:0] = 32'd7;
    step_ns = 10'd3; prescale = 8'd1; tick = 1'b1;
    clear_mon();
    pulse_alarm(2'b01);
    cyc(6);
    pulse_alarm(2'b01);                // R9: ignored while running
    cyc(25);
    chk(rc[0] >= 5, 1, "R4 enough pulses");
    check_spacing(0, 3, 10, 4, "R4 R9 spacing with carried excess");
    chk(hl[0], 1, "R5 width 1 at prescale 1");

    // R6 toggle mode, then R7 disable
    do_reset();
    ctrl_word = 24'h408080; interval_ns[95:64] = 32'd4;
    step_ns = 10'd1; prescale = 8'd1; tick = 1'b1;
    pulse_alarm(2'b01);
    chk(pulse_out[2], 1, "R6 toggles high on first firing");
    cyc(4);
    chk(pulse_out[2], 1, "R6 holds until next firing");
    cyc(1);
    chk(pulse_out[2], 0, "R6 toggles low on second firing");
    cyc(5);
    chk(pulse_out[2], 1, "R6 toggles high again");
    ctrl_word = 24'hC08080; cyc(1);
    chk(pulse_out[2], 0, "R7 disable drops output");
    event_clr = 8'hFF; cyc(1); event_clr = 8'h00;
    clear_mon();
    pulse_alarm(2'b01);
    cyc(10);
    chk(rc[2], 0, "R7 no pulse while disabled");
    chk(event_flags, 0, "R7 no flag while disabled");
    ctrl_word = 24'h408080;
    cyc(15);
    chk(rc[2], 0, "R7 waits for alarm after enable");
    pulse_alarm(2'b01);
    chk(pulse_out[2], 1, "R7 re-armed by new alarm");

    // R4/R5/R10 random rounds
    for (int r = 0; r < 5; r++) begin
      longint s, d;
      longint p [3];
      int     w [3];
      logic   as [3];
      s = 1 + $urandom % 12;
      d = 1 + $urandom % 3;
      for (int c = 0; c < 3; c++) begin
        longint q;
        p[c] = 4 * s + $urandom % (26 * s + 1);
        q = (p[c] / s - 2) / d;
        w[c] = int'($urandom % (q + 1));
        if (w[c] > 31) w[c] = 31;
        as[c] = 1'($urandom % 2);
      end
      do_reset();
      for (int c = 0; c < 3; c++) begin
        ctrl_word[c*8 +: 8] = {2'b00, as[c], 5'(w[c])};
        interval_ns[c*32 +: 32] = 32'(p[c] - s);
      end
      step_ns = 10'(s); prescale = 8'(d); tick = 1'b1;
      clear_mon();
      pulse_alarm(2'b11);
      cyc(150);
      for (int c = 0; c < 3; c++) begin
        if (w[c] == 0) begin
          chk(rc[c], 0, "R5 random width zero silent");
        end else begin
          chk(rc[c] >= 5, 1, "R10 random channel running");
          check_spacing(c, s, p[c], 4, "R4 R10 random spacing");
          chk(hl[c], w[c] * d, "R5 random width");
        end
        chk(event_flags[7-c], 1, "R8 random flag");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule